// File: doc/BRIEF.md
# Best-Match Clock Level Selector

This block searches a table of available source clock rates for the entry that, divided by a whole number, comes closest to a requested output frequency without going above it. A controller pulses a start input along with the requested frequency, an exact-match flag and the number of valid table entries. The block then walks the table through its own read port, one entry after another, and returns the winning index, that entry's rate and a pass/fail status with a single-cycle done pulse.

For each entry it takes the smallest whole divider that keeps the output at or below the request. It scores the entry by how far the divided rate falls short of the request. Both divisions share one iterative restoring divider, so a search takes roughly seventy cycles per entry. The search ends early as soon as an entry hits the request exactly.

Top module: `lvl_pick`

## Requirements
- R1: After reset, done_o, busy_o and ok_o are 0 and sel_idx_o and sel_rate_o are 0.
- R2: A start with a requested frequency of zero reads no table entry and raises done_o in the cycle after start with ok_o = 0.
- R3: A start with an entry count of zero raises done_o in the cycle after start with ok_o = 0.
- R4: For each entry of rate r, the divider is d = ceil(r / req), the candidate output is floor(r / d) and its shortfall is req minus that output. An entry of rate zero has shortfall equal to req.
- R5: An entry becomes the selection only if its shortfall is strictly below the best shortfall so far, which starts at all ones. On equal shortfall the lower index is kept.
- R6: When an entry's shortfall is zero, the search ends at that entry with ok_o = 1, and no higher index is put on tbl_idx_o.
- R7: If no entry has zero shortfall, ok_o is 0 when exact_i was 1 at start. Otherwise ok_o is 1 and the best entry is reported.
- R8: An entry count above the table depth LVL_N is treated as LVL_N.
- R9: A start pulse while busy_o is 1 is ignored, and the running search completes with its original inputs.
- R10: done_o is high for exactly one cycle, the cycle after the final decision. ok_o, sel_idx_o and sel_rate_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| req_i | input | RATE_W | Requested output frequency |
| exact_i | input | 1 | Require a zero-shortfall match |
| count_i | input | CNT_W | Number of valid table entries |
| tbl_idx_o | output | IDX_W | Table read index |
| tbl_rate_i | input | RATE_W | Table rate at tbl_idx_o, same cycle |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Search succeeded |
| sel_idx_o | output | IDX_W | Selected table index |
| sel_rate_o | output | RATE_W | Selected source rate |

## Verification
The assertions check on every cycle the behaviours that sit at the edges of the block: the single-cycle done pulse, the immediate rejection of a zero request or an empty table, and the results staying stable while idle. The arithmetic is left to the bench scenarios. These cover the rounded-up divider, the one-sided shortfall ranking and the lowest-index tie rule. They also cover the early stop on an exact hit, seen as the highest index read, along with the exact-flag rejection, count clamping and a start pulse that arrives mid-search.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE1,
    ST_WAIT1,
    ST_ISSUE2,
    ST_WAIT2,
    ST_CMP,
    ST_FIN
  } lvl_state_e;
endpackage

// File: rtl/lvl_div.sv
module lvl_div #(
  parameter int W = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    shifted;
  logic          ge;

  assign shifted = {rem_q, quo_q[W-1]};
  assign ge      = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dvd_i;
        dvs_q <= dvs_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? W'(shifted - {1'b0, dvs_q}) : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/lvl_best.sv
module lvl_best #(
  parameter int RATE_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [RATE_W-1:0] gap_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              better_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [RATE_W-1:0] gap_q;

  assign better_o = gap_i < gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '1;
      idx_o  <= '0;
      rate_o <= '0;
    end else if (clr_i) begin
      gap_q <= '1;
    end else if (upd_i && better_o) begin
      gap_q  <= gap_i;
      idx_o  <= idx_i;
      rate_o <= rate_i;
    end
  end
endmodule

// File: rtl/lvl_pick.sv
module lvl_pick
  import lvl_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int LVL_N  = 32,
  parameter int IDX_W  = $clog2(LVL_N),
  parameter int CNT_W  = $clog2(LVL_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] req_i,
  input  logic              exact_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [IDX_W-1:0]  tbl_idx_o,
  input  logic [RATE_W-1:0] tbl_rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [IDX_W-1:0]  sel_idx_o,
  output logic [RATE_W-1:0] sel_rate_o
);
  localparam int DW = RATE_W + 1;

  lvl_state_e        st_q;
  logic [RATE_W-1:0] req_q, rate_q, quot_q, gap;
  logic [DW-1:0]     div_q, dvd, dvs, quo;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q, cnt_in;
  logic              exact_q, div_go, div_done, better, last;

  assign cnt_in = (count_i > CNT_W'(LVL_N)) ? CNT_W'(LVL_N) : count_i;
  assign gap    = req_q - quot_q;
  assign last   = (CNT_W'(idx_q) + 1'b1) == cnt_q;
  assign div_go = (st_q == ST_ISSUE1) || (st_q == ST_ISSUE2 && div_q != '0);

  // ceil(r/req) as (r+req-1)/req, then r/d
  always_comb begin
    if (st_q == ST_ISSUE1) begin
      dvd = {1'b0, tbl_rate_i} + {1'b0, req_q} - 1'b1;
      dvs = {1'b0, req_q};
    end else begin
      dvd = {1'b0, rate_q};
      dvs = div_q;
    end
  end

  lvl_div #(.W(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go),
    .dvd_i  (dvd),
    .dvs_i  (dvs),
    .quo_o  (quo),
    .done_o (div_done)
  );

  lvl_best #(.RATE_W(RATE_W), .IDX_W(IDX_W)) u_best (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q == ST_IDLE && start_i),
    .upd_i   (st_q == ST_CMP),
    .gap_i   (gap),
    .idx_i   (idx_q),
    .rate_i  (rate_q),
    .better_o(better),
    .idx_o   (sel_idx_o),
    .rate_o  (sel_rate_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      req_q   <= '0;
      rate_q  <= '0;
      quot_q  <= '0;
      div_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      exact_q <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          req_q   <= req_i;
          exact_q <= exact_i;
          cnt_q   <= cnt_in;
          idx_q   <= '0;
          ok_o    <= 1'b0;
          st_q    <= (req_i == '0 || cnt_in == '0) ? ST_FIN : ST_ISSUE1;
        end
        ST_ISSUE1: begin
          rate_q <= tbl_rate_i;
          st_q   <= ST_WAIT1;
        end
        ST_WAIT1: if (div_done) begin
          div_q <= quo;
          st_q  <= ST_ISSUE2;
        end
        ST_ISSUE2: if (div_q == '0) begin
          quot_q <= '0;
          st_q   <= ST_CMP;
        end else begin
          st_q <= ST_WAIT2;
        end
        ST_WAIT2: if (div_done) begin
          quot_q <= quo[RATE_W-1:0];
          st_q   <= ST_CMP;
        end
        ST_CMP: begin
          if (gap == '0) begin
            ok_o <= 1'b1;
            st_q <= ST_FIN;
          end else if (last) begin
            ok_o <= !exact_q;
            st_q <= ST_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_ISSUE1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tbl_idx_o = idx_q;
  assign busy_o    = st_q != ST_IDLE;
  assign done_o    = st_q == ST_FIN;

  wire unused_ok = better;
endmodule

// File: rtl/lvl_pick_chk.sv
module lvl_pick_chk #(
  parameter int RATE_W = 32,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [RATE_W-1:0] req_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ok_o,
  input logic [IDX_W-1:0]  sel_idx_o
);
  p_zero_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && req_i == '0 |=> done_o && !ok_o);

  p_empty_tbl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && count_i == '0 |=> done_o && !ok_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(sel_idx_o) && $stable(ok_o));
endmodule

bind lvl_pick lvl_pick_chk #(.RATE_W(RATE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .req_i    (req_i),
  .count_i  (count_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .ok_o     (ok_o),
  .sel_idx_o(sel_idx_o)
);

// File: tb/lvl_pick_test.sv
module lvl_pick_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req = '0;
  logic        exact = 1'b0;
  logic [5:0]  count = '0;
  logic [4:0]  tbl_idx;
  logic [31:0] tbl_rate;
  logic        busy, done, ok;
  logic [4:0]  sel_idx;
  logic [31:0] sel_rate;
  logic [31:0] tbl [32];
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #10 clk = ~clk;
  assign tbl_rate = tbl[tbl_idx];

  lvl_pick uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_i(req), .exact_i(exact),
    .count_i(count), .tbl_idx_o(tbl_idx), .tbl_rate_i(tbl_rate), .busy_o(busy),
    .done_o(done), .ok_o(ok), .sel_idx_o(sel_idx), .sel_rate_o(sel_rate)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference search: R4, R5, R6, R7, R8
  task automatic model(input longint rq, input bit ex, input int cnt,
                       output bit e_ok, output int e_idx, output int e_last);
    longint best, r, d, q, g;
    int n;
    n = (cnt > 32) ? 32 : cnt;
    best = 64'hFFFF_FFFF; e_idx = 0; e_last = n - 1; e_ok = 0;
    if (rq == 0 || n == 0) return;
    for (int i = 0; i < n; i++) begin
      r = longint'(tbl[i]);
      d = (r == 0) ? 0 : (r + rq - 1) / rq;
      q = (d == 0) ? 0 : r / d;
      g = rq - q;
      if (g < best) begin best = g; e_idx = i; end
      if (g == 0) begin e_last = i; e_ok = 1; return; end
    end
    e_ok = !ex;
  endtask

  task automatic run(input logic [31:0] rq, input bit ex, input int cnt,
                     input int poke_at, input string tag);
    bit e_ok; int e_idx, e_last, mx, n;
    model(longint'(rq), ex, cnt, e_ok, e_idx, e_last);
    @(negedge clk);
    start = 1'b1; req = rq; exact = ex; count = 6'(cnt);
    @(negedge clk);
    start = 1'b0;
    mx = 0; n = 0;
    while (!done && n < 5000) begin
      if (int'(tbl_idx) > mx) mx = int'(tbl_idx);
      @(negedge clk);
      n++;
      start = (n == poke_at);
      if (n == poke_at) begin req = rq ^ 32'h55; count = 6'd1; exact = !ex; end
    end
    start = 1'b0;
    chk({tag, " R10 done seen"}, done, 1);
    chk({tag, " R7 ok"}, ok, e_ok);
    if ((rq == 0 || cnt == 0) && n != 0) chk({tag, " R2 R3 done latency"}, n, 0);
    if (e_ok) begin
      chk({tag, " R5 index"}, sel_idx, e_idx);
      chk({tag, " R4 rate"}, sel_rate, tbl[e_idx]);
      if (rq != 0 && cnt != 0) chk({tag, " R6 last read"}, mx, e_last);
    end
    @(negedge clk);
    chk({tag, " R10 pulse ends"}, done, 0);
    if (e_ok) chk({tag, " R10 hold"}, sel_idx, e_idx);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 32; i++) tbl[i] = 32'd1000 + 32'(i) * 7;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ok", ok, 0);
    chk("R1 sel_idx", sel_idx, 0);
    chk("R1 sel_rate", sel_rate, 0);
    rst_n = 1'b1;

    run(32'd0, 1'b0, 8, -1, "zero req R2");
    run(32'd100, 1'b0, 0, -1, "empty R3");
    // exact hit mid-table: 1014/2 = 507
    run(32'd507, 1'b0, 32, -1, "hit R6");
    run(32'd333, 1'b1, 4, -1, "exact miss R7");
    run(32'd333, 1'b0, 4, -1, "inexact R7");
    // ties: equal rates at 2 and 5
    for (int i = 0; i < 8; i++) tbl[i] = 32'd997 + 32'(i);
    tbl[5] = tbl[2]; tbl[0] = 32'd0;
    run(32'd450, 1'b0, 8, -1, "tie R5");
    run(32'd2000, 1'b0, 1, -1, "zero rate R4");
    tbl[31] = 32'hFFFF_FFFF;
    run(32'd3, 1'b0, 63, -1, "clamp R8");
    run(32'd450, 1'b0, 8, 40, "busy start R9");
    for (int k = 0; k < 22; k++) begin
      for (int i = 0; i < 32; i++) tbl[i] = 32'($urandom_range(2000, 0));
      run(32'($urandom_range(400, 1)), 1'($urandom_range(1, 0)),
          int'($urandom_range(40, 1)), -1, "random R4");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule